// File: doc/BRIEF.md
# Interrupt presenter register front-end

This block is the memory-mapped register face of one per-thread interrupt presenter. It sits on a simple request bus covering a 4 KB window, checks the size and byte lane of every access, and turns each legal access into read data or into a one-cycle command strobe for a separate presenter core. The core holds the pending-interrupt state and does the priority arbitration. The front-end only decodes and forwards.

The core supplies three values. The first is the current poll value, a 32-bit vector whose top byte is the current priority. The second is the value an accept would deliver. The third is the present IPI priority. The front-end issues these strobes toward the core: poll, accept, set current priority, end-of-interrupt and set IPI priority. It also holds a small bank of plain 32-bit link registers.

The layout is big-endian, so byte lane 0 of each word is bits [31:24]. Some offsets do different things depending on the access size. A word read of the accept register consumes an interrupt. A byte access at the same offset only touches the priority byte.

Top module: `irq_present_regs`

## Requirements
- R1: After reset, every link register reads 0, no command strobe and no error are asserted, and the read data register holds 0.
- R2: An access is byte-0 only when `req_size` is 1 and `req_addr[1:0]` is 0. It is a word access when `req_size` is 4, and a word access decodes by `req_addr[11:2]` whatever its low bits are. Sizes 0, 2, 3 and 5 to 7, and byte accesses at a nonzero lane, are bad.
- R3: At offset 0x0, a word read returns `core_poll_val`. A byte-0 read returns `{core_poll_val[31:24], 24'h0}`. Both pulse `cmd_poll`. Every write there is bad.
- R4: At offset 0x4, a byte-0 read returns `{core_poll_val[31:24], 24'h0}` and pulses `cmd_poll`. A word read returns the `core_accept_val` present in the request cycle and pulses `cmd_accept`.
- R5: At offset 0x4, a byte-0 write pulses `cmd_set_cppr` with `cmd_data = {24'h0, req_wdata[31:24]}`. A word write pulses `cmd_eoi` with `cmd_data = req_wdata`.
- R6: At offset 0xC, a byte-0 read returns `{core_ipi_prio, 24'h0}`. A byte-0 write pulses `cmd_set_ipi` with `cmd_data = {24'h0, req_wdata[31:24]}`. Every other access there is bad.
- R7: Offsets 0x10, 0x14 and 0x18 are link registers 0, 1 and 2. They accept word reads and word writes only, and a read returns the last value written.
- R8: A bad access pulses `rsp_err`. A bad read returns 0xFFFFFFFF. A bad write fires no strobe and leaves every link register unchanged. Offsets with no register (for example 0x8, 0x1C, 0xFFC) are always bad.
- R9: `rsp_rdata`, `rsp_err` and the strobes are registered, so they appear in the cycle after the request. Each strobe and `rsp_err` lasts one cycle per request, and at most one strobe is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, lane 0 in [31:24] |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| rsp_err | output | 1 | One-cycle bad-access pulse |
| core_poll_val | input | 32 | Pending vector from the core |
| core_accept_val | input | 32 | Value an accept returns |
| core_ipi_prio | input | 8 | Current IPI priority |
| cmd_poll | output | 1 | Poll strobe |
| cmd_accept | output | 1 | Accept strobe |
| cmd_set_cppr | output | 1 | Set current priority strobe |
| cmd_eoi | output | 1 | End-of-interrupt strobe |
| cmd_set_ipi | output | 1 | Set IPI priority strobe |
| cmd_data | output | 32 | Operand of the write strobes |

## Verification
On every cycle, the assertions check the following:
- at most one strobe is active;
- an error never coincides with a strobe;
- a bad read carries all ones;
- accept data and end-of-interrupt data match the request-cycle values;
- links hold their value across cycles without a write;
- nothing is emitted without a request.

Only the bench scenarios can show the rest of the behaviour. That covers the full decode of each offset against each size and lane, the byte placement on lane 0, link read-back after legal and refused writes, and back-to-back accesses.

// File: rtl/irq_present_regs.sv
module irq_present_regs #(
  parameter int          AW       = 12,
  parameter int          NLINK    = 3,
  parameter logic [31:0] BAD_DATA = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  input  logic [31:0]   core_poll_val,
  input  logic [31:0]   core_accept_val,
  input  logic [7:0]    core_ipi_prio,
  output logic          cmd_poll,
  output logic          cmd_accept,
  output logic          cmd_set_cppr,
  output logic          cmd_eoi,
  output logic          cmd_set_ipi,
  output logic [31:0]   cmd_data
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IX_POLL = IW'(0);
  localparam logic [IW-1:0] IX_XR   = IW'(1);
  localparam logic [IW-1:0] IX_IPI  = IW'(3);
  localparam int LINK_BASE = 4;

  wire [IW-1:0] idx   = req_addr[AW-1:2];
  wire          byte0 = (req_size == 3'd1) && (req_addr[1:0] == 2'b00);
  wire          word  = (req_size == 3'd4);
  wire [31:0]   top_b = {core_poll_val[31:24], 24'h0};

  logic [NLINK-1:0][31:0] link_q;
  logic [NLINK-1:0]       link_we;
  logic [31:0] rd_d, cd_d;
  logic ok, s_poll, s_acc, s_cppr, s_eoi, s_ipi;

  always_comb begin
    ok = 1'b0; rd_d = BAD_DATA; cd_d = req_wdata; link_we = '0;
    s_poll = 1'b0; s_acc = 1'b0; s_cppr = 1'b0; s_eoi = 1'b0; s_ipi = 1'b0;
    if (idx == IX_POLL) begin
      if (!req_write && (word || byte0)) begin
        ok = 1'b1; s_poll = 1'b1;
        rd_d = word ? core_poll_val : top_b;
      end
    end else if (idx == IX_XR) begin
      if (req_write) begin
        if (byte0) begin ok = 1'b1; s_cppr = 1'b1; cd_d = {24'h0, req_wdata[31:24]}; end
        else if (word) begin ok = 1'b1; s_eoi = 1'b1; end
      end else begin
        if (byte0) begin ok = 1'b1; s_poll = 1'b1; rd_d = top_b; end
        else if (word) begin ok = 1'b1; s_acc = 1'b1; rd_d = core_accept_val; end
      end
    end else if (idx == IX_IPI) begin
      if (byte0) begin
        ok = 1'b1;
        if (req_write) begin s_ipi = 1'b1; cd_d = {24'h0, req_wdata[31:24]}; end
        else rd_d = {core_ipi_prio, 24'h0};
      end
    end else begin
      for (int k = 0; k < NLINK; k++) begin
        if (idx == IW'(LINK_BASE + k) && word) begin
          ok = 1'b1;
          if (req_write) link_we[k] = 1'b1;
          else rd_d = link_q[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0; rsp_rdata <= '0; rsp_err <= 1'b0; cmd_data <= '0;
      cmd_poll <= 1'b0; cmd_accept <= 1'b0; cmd_set_cppr <= 1'b0;
      cmd_eoi <= 1'b0; cmd_set_ipi <= 1'b0;
    end else begin
      rsp_err      <= req_valid && !ok;
      cmd_poll     <= req_valid && s_poll;
      cmd_accept   <= req_valid && s_acc;
      cmd_set_cppr <= req_valid && s_cppr;
      cmd_eoi      <= req_valid && s_eoi;
      cmd_set_ipi  <= req_valid && s_ipi;
      if (req_valid && !req_write) rsp_rdata <= ok ? rd_d : BAD_DATA;
      if (req_valid && (s_cppr || s_eoi || s_ipi)) cmd_data <= cd_d;
      for (int k = 0; k < NLINK; k++)
        if (req_valid && link_we[k]) link_q[k] <= req_wdata;
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_poll, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_ipi}));
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !(cmd_poll || cmd_accept || cmd_set_cppr || cmd_eoi || cmd_set_ipi));
  a_r8_bad_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !$past(req_write)) |-> rsp_rdata == BAD_DATA);
  a_r4_accept_value: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> rsp_rdata == $past(core_accept_val));
  a_r5_eoi_data: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_eoi |-> cmd_data == $past(req_wdata));
  a_r7_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |-> $stable(link_q));
  a_r9_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err || cmd_poll || cmd_accept || cmd_set_cppr || cmd_eoi || cmd_set_ipi)
      |-> $past(req_valid));
endmodule

// File: tb/sim_irq_present_regs.sv
module sim_irq_present_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] core_poll_val = '0, core_accept_val = '0;
  logic [7:0]  core_ipi_prio = '0;
  logic [31:0] rsp_rdata, cmd_data;
  logic rsp_err, cmd_poll, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_ipi;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_present_regs u0 (.*);

  typedef struct {
    logic        chk_rd;
    logic [31:0] rd;
    logic        err;
    logic [4:0]  stb;
    logic [31:0] cdata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // strobe order: {poll, accept, cppr, eoi, ipi}
  task automatic acc(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input logic [31:0] rd, input logic err,
                     input logic [4:0] stb, input logic [31:0] cd, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    e.chk_rd = !wr && !$isunknown(rd); e.rd = rd; e.err = err; e.stb = stb;
    e.cdata = cd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); req_valid = 0; end
  endtask

  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      exp_t e;
      #2;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++; $display("FAIL scoreboard: actual empty expected item");
      end else begin
        e = exp_q.pop_front();
        check({e.tag, " err"}, {31'h0, rsp_err}, {31'h0, e.err});
        check({e.tag, " strobes"},
              {27'h0, cmd_poll, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_ipi},
              {27'h0, e.stb});
        if (e.chk_rd) check({e.tag, " rdata"}, rsp_rdata, e.rd);
        if (e.stb[2:0] != 3'b000) check({e.tag, " cmd_data"}, cmd_data, e.cdata);
      end
    end
  end

  localparam logic [31:0] BAD = 32'hFFFF_FFFF;
  localparam logic [31:0] X32 = 32'hx;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 strobes", {27'h0, cmd_poll, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_ipi}, 32'h0);
        check("R1 err", {31'h0, rsp_err}, 32'h0);
        check("R1 rdata", rsp_rdata, 32'h0);
        acc(0, 12'h010, 4, 0, 32'h0, 0, 5'b00000, 0, "R1 link0");
        acc(0, 12'h014, 4, 0, 32'h0, 0, 5'b00000, 0, "R1 link1");
        acc(0, 12'h018, 4, 0, 32'h0, 0, 5'b00000, 0, "R1 link2");
        idle(1);
        core_poll_val = 32'hA512_3456; core_accept_val = 32'h5A00_BEEF; core_ipi_prio = 8'h3C;
        // R3 poll register
        acc(0, 12'h000, 4, 0, 32'hA512_3456, 0, 5'b10000, 0, "R3 word poll");
        acc(0, 12'h000, 1, 0, 32'hA500_0000, 0, 5'b10000, 0, "R3 byte poll");
        acc(1, 12'h000, 4, 32'h1234_5678, X32, 1, 5'b00000, 0, "R3 write bad");
        // R2 lane and size
        acc(0, 12'h001, 1, 0, BAD, 1, 5'b00000, 0, "R2 byte lane1");
        acc(0, 12'h000, 2, 0, BAD, 1, 5'b00000, 0, "R2 size2");
        acc(0, 12'h000, 0, 0, BAD, 1, 5'b00000, 0, "R2 size0");
        acc(1, 12'h00D, 1, 32'hAA00_0000, X32, 1, 5'b00000, 0, "R2 byte lane1 ipi");
        acc(0, 12'h006, 4, 0, 32'h5A00_BEEF, 0, 5'b01000, 0, "R2 unaligned word accept");
        // R4 accept register reads
        acc(0, 12'h004, 1, 0, 32'hA500_0000, 0, 5'b10000, 0, "R4 byte poll");
        core_accept_val = 32'h0700_0042;
        acc(0, 12'h004, 4, 0, 32'h0700_0042, 0, 5'b01000, 0, "R4 word accept");
        // R5 writes at accept register
        acc(1, 12'h004, 1, 32'h77AB_CDEF, X32, 0, 5'b00100, 32'h0000_0077, "R5 cppr");
        acc(1, 12'h004, 4, 32'hDEAD_BEEF, X32, 0, 5'b00010, 32'hDEAD_BEEF, "R5 eoi");
        acc(1, 12'h004, 3, 32'h1111_1111, X32, 1, 5'b00000, 0, "R8 size3 write");
        // R6 IPI priority
        acc(0, 12'h00C, 1, 0, 32'h3C00_0000, 0, 5'b00000, 0, "R6 byte read");
        acc(1, 12'h00C, 1, 32'h9100_0000, X32, 0, 5'b00001, 32'h0000_0091, "R6 byte write");
        acc(0, 12'h00C, 4, 0, BAD, 1, 5'b00000, 0, "R6 word read bad");
        idle(2);
        // R7 links
        acc(1, 12'h010, 4, 32'h1111_1111, X32, 0, 5'b00000, 0, "R7 wr0");
        acc(1, 12'h014, 4, 32'h2222_2222, X32, 0, 5'b00000, 0, "R7 wr1");
        acc(1, 12'h018, 4, 32'h3333_3333, X32, 0, 5'b00000, 0, "R7 wr2");
        acc(0, 12'h010, 4, 0, 32'h1111_1111, 0, 5'b00000, 0, "R7 rd0");
        acc(0, 12'h014, 4, 0, 32'h2222_2222, 0, 5'b00000, 0, "R7 rd1");
        acc(0, 12'h018, 4, 0, 32'h3333_3333, 0, 5'b00000, 0, "R7 rd2");
        // R8 bad accesses
        acc(1, 12'h010, 1, 32'hFF00_0000, X32, 1, 5'b00000, 0, "R8 byte link write");
        acc(0, 12'h010, 4, 0, 32'h1111_1111, 0, 5'b00000, 0, "R8 link0 kept");
        acc(0, 12'h010, 1, 0, BAD, 1, 5'b00000, 0, "R8 byte link read");
        acc(0, 12'h008, 4, 0, BAD, 1, 5'b00000, 0, "R8 hole 0x8");
        acc(0, 12'h01C, 4, 0, BAD, 1, 5'b00000, 0, "R8 hole 0x1C");
        acc(1, 12'hFFC, 4, 32'h5555_5555, X32, 1, 5'b00000, 0, "R8 write 0xFFC");
        acc(1, 12'h014, 2, 32'h6666_6666, X32, 1, 5'b00000, 0, "R8 size2 link write");
        acc(0, 12'h014, 4, 0, 32'h2222_2222, 0, 5'b00000, 0, "R8 link1 kept");
        idle(1);
        @(negedge clk);
        // R9 pulses last one cycle
        check("R9 strobes idle", {27'h0, cmd_poll, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_ipi}, 32'h0);
        check("R9 err idle", {31'h0, rsp_err}, 32'h0);
        check("R9 rdata held", rsp_rdata, 32'h2222_2222);
        idle(2);
      end
      begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule